// File: doc/BRIEF.md
# Oversampled SPI Bus Monitor

This block listens to an SPI bus without driving it. All four bus lines (serial clock, controller-to-peripheral data, peripheral-to-controller data, chip select) are brought into the block's own faster clock through two-flop synchronisers. Serial clock edges are then found by comparing successive samples. On every capture edge one bit is taken from each data line. When the configured number of bits has been gathered, both data words are presented together for one cycle. With each word the block also reports a warning flag and how many system-clock ticks the word took.

Every change of the chip-select line is reported as an event that carries the old and the new level. The same change throws away any partly assembled word. Clock polarity, clock phase, bit order, word length, chip-select polarity and the enables of the two data lanes and of chip-select monitoring are static configuration inputs. They are changed only between words. Turning the measured tick count into a bitrate is left to the consumer, as is any meaning of the words above the bit level.

Top module: `spi_mon`

## Requirements
- R1: A bit is captured on a serial-clock rising edge when `cfg_cpol` equals `cfg_cpha`, and on a falling edge otherwise. The clock idles at the `cfg_cpol` level.
- R2: With `cfg_lsb_first`=0, the bit captured at index k of a word goes to data bit (length-1-k). With `cfg_lsb_first`=1 it goes to data bit k.
- R3: The word length is `cfg_word_len`, from 1 to 32; a value of 0 or above 32 means 32. After that many captures, `word_valid` pulses for exactly one cycle, three system clocks after the final capture edge reaches the pins, and assembly restarts at index 0.
- R4: With chip-select monitoring enabled, every change of the synchronised chip-select level produces a one-cycle `cs_evt_valid`. `cs_evt_old` and `cs_evt_new` carry the previous and new levels, and they always differ.
- R5: A monitored chip-select change discards the partial word. If a capture edge falls in the same cycle as the change, that bit becomes index 0 of the new word.
- R6: `word_warn` is 1 when chip select read as deasserted at any capture of the word. Deasserted means level 1 when `cfg_cs_active_high`=0 and level 0 when it is 1. The flag starts clear for each word.
- R7: `word_ticks` equals the system-clock cycles from the first capture of the word to its last, inclusive, so a one-bit word reports 1. The value saturates at the maximum of the field.
- R8: A lane whose enable (`cfg_mosi_en` or `cfg_miso_en`) is 0 reports all-zero data, while the other lane is unaffected.
- R9: With `cfg_cs_en`=0, chip-select changes produce no events, never discard a partial word, and never set the warning.
- R10: After reset all outputs are 0. The levels present on the bus at reset release produce no chip-select event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: on trailing edge |
| cfg_lsb_first | input | 1 | 1: first bit is data bit 0 |
| cfg_word_len | input | 6 | Bits per word (1..32; 0 or >32 means 32) |
| cfg_cs_active_high | input | 1 | 1: chip select is asserted when high |
| cfg_cs_en | input | 1 | Enable chip-select monitoring |
| cfg_mosi_en | input | 1 | Enable controller-to-peripheral lane |
| cfg_miso_en | input | 1 | Enable peripheral-to-controller lane |
| bus_sck | input | 1 | Serial clock line (asynchronous) |
| bus_mosi | input | 1 | Controller-to-peripheral data line (asynchronous) |
| bus_miso | input | 1 | Peripheral-to-controller data line (asynchronous) |
| bus_cs | input | 1 | Chip-select line (asynchronous) |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_mosi | output | 32 | Controller-to-peripheral word |
| word_miso | output | 32 | Peripheral-to-controller word |
| word_warn | output | 1 | Chip select was deasserted during the word |
| word_ticks | output | 16 | Word duration in system-clock ticks |
| cs_evt_valid | output | 1 | One-cycle strobe for a chip-select change |
| cs_evt_old | output | 1 | Chip-select level before the change |
| cs_evt_new | output | 1 | Chip-select level after the change |

## Verification
A bit counter that drifts out of step shows at the ports as a word strobe that comes early or late. That word carries shifted or mixed-up data, and all later words stay misaligned until the next chip-select change resynchronises them. The scoreboard therefore flags it at the first affected word. A wrong edge selection shows up in the first word of the offending mode as bit-shifted data. A stale warning flag or a wrong tick count shows up in the same word strobe that carries it. A missed clear on chip-select change shows up in the next word, as leftover bits from the discarded fragment.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    // Lane indices inside the packed per-lane vectors.
    localparam int unsigned LANE_MOSI = 0;
    localparam int unsigned LANE_MISO = 1;
    localparam int unsigned NUM_LANES = 2;

    // Static configuration gathered from the top-level pins.
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic cs_active_high;
        logic cs_en;
    } spi_mon_cfg_t;

endpackage

// File: rtl/spi_mon_sync.sv
// spi_mon_sync: brings W asynchronous lines into the clock domain through a
// STAGES-deep flop chain and keeps the previous synchronised sample beside
// the current one. 'vld' rises once both samples hold real bus data, so a
// comparison never sees the reset value of the chain.
// Assumes: each line is held for at least one clock period between changes.
module spi_mon_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv,
    output logic         vld
);

    logic [W-1:0]  chain [STAGES];
    logic [STAGES:0] fill;

    // Shift samples through the chain and remember the last synchronised one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prv  <= '0;
            fill <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prv  <= chain[STAGES-1];
            fill <= {fill[STAGES-1:0], 1'b1};
        end
    end

    assign cur = chain[STAGES-1];
    assign vld = fill[STAGES];

endmodule

// File: rtl/spi_mon_edge.sv
// spi_mon_edge: turns synchronised samples into per-cycle events: a capture
// strike on the selected serial-clock edge, a monitored chip-select change,
// and the chip-select "deasserted" level under the configured polarity.
// Assumes: configuration is static while a word is in progress.
module spi_mon_edge
    import spi_mon_pkg::*;
(
    input  spi_mon_cfg_t cfg,
    input  logic         vld,
    input  logic         sck_cur,
    input  logic         sck_prv,
    input  logic         cs_cur,
    input  logic         cs_prv,
    output logic         capture,
    output logic         cs_chg,
    output logic         cs_off
);

    logic sck_moved;
    logic capture_level;

    // Pick the edge direction: equal polarity and phase capture on the rise.
    always_comb begin
        sck_moved     = vld && (sck_cur != sck_prv);
        capture_level = ~(cfg.cpol ^ cfg.cpha);
        capture       = sck_moved && (sck_cur == capture_level);
    end

    // Chip-select change and deasserted level, both gated by the monitor enable.
    always_comb begin
        cs_chg = cfg.cs_en && vld && (cs_cur != cs_prv);
        cs_off = cfg.cs_en && (cfg.cs_active_high ? ~cs_cur : cs_cur);
    end

endmodule

// File: rtl/spi_mon_word.sv
// spi_mon_word: assembles one word per lane from capture strikes, tracks the
// sticky chip-select warning and the inclusive tick span, and registers the
// finished word with a one-cycle strobe. A chip-select change restarts the
// word; a capture in the same cycle becomes index 0 of the fresh word.
// Assumes: word_len and lsb_first change only while no word is in progress.
module spi_mon_word
    import spi_mon_pkg::*;
#(
    parameter int unsigned MAX_W  = 32,
    parameter int unsigned TICK_W = 16,
    parameter int unsigned CNT_W  = $clog2(MAX_W + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  capture,
    input  logic                                  cs_chg,
    input  logic                                  cs_off,
    input  logic [NUM_LANES-1:0]                  lane_bit,
    input  logic [NUM_LANES-1:0]                  lane_en,
    input  logic                                  lsb_first,
    input  logic [CNT_W-1:0]                      word_len,
    output logic                                  word_valid,
    output logic [NUM_LANES-1:0][MAX_W-1:0]       word_data,
    output logic                                  word_warn,
    output logic [TICK_W-1:0]                     word_ticks
);

    localparam logic [CNT_W-1:0]  LEN_MAX  = CNT_W'(MAX_W);
    localparam logic [TICK_W-1:0] TICK_TOP = '1;

    logic [CNT_W-1:0]  bitcnt;
    logic [CNT_W-1:0]  len_eff;
    logic [CNT_W-1:0]  cnt0;
    logic [CNT_W-1:0]  pos;
    logic              done;
    logic              warn;
    logic              warn_new;
    logic [TICK_W-1:0] tick;
    logic [TICK_W-1:0] dur_now;

    // Clamp the length and work out where this capture lands in the word.
    always_comb begin
        len_eff  = (word_len == '0 || word_len > LEN_MAX) ? LEN_MAX : word_len;
        cnt0     = cs_chg ? '0 : bitcnt;
        pos      = lsb_first ? cnt0 : (len_eff - CNT_W'(1) - cnt0);
        done     = capture && ((cnt0 + CNT_W'(1)) == len_eff);
        warn_new = (cs_chg ? 1'b0 : warn) | cs_off;
        dur_now  = (cnt0 == '0) ? TICK_W'(1)
                 : ((tick == TICK_TOP) ? tick : tick + TICK_W'(1));
    end

    // Per-lane shift register and registered word output.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [MAX_W-1:0] sr;
        logic [MAX_W-1:0] sr_new;

        // Merge the captured bit into the (possibly restarted) partial word.
        always_comb begin
            sr_new = (cs_chg ? '0 : sr) | (MAX_W'(lane_bit[g]) << pos);
        end

        // Hold the partial word; clear it on completion or chip-select change.
        always_ff @(posedge clk) begin
            if (!rst_n)       sr <= '0;
            else if (capture) sr <= done ? '0 : sr_new;
            else if (cs_chg)  sr <= '0;
        end

        // Publish the finished word, zero when the lane is disabled.
        always_ff @(posedge clk) begin
            if (!rst_n)    word_data[g] <= '0;
            else if (done) word_data[g] <= lane_en[g] ? sr_new : '0;
        end
    end

    // Bit counter and sticky warning for the word in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            warn   <= 1'b0;
        end else if (capture) begin
            bitcnt <= done ? '0 : cnt0 + CNT_W'(1);
            warn   <= done ? 1'b0 : warn_new;
        end else if (cs_chg) begin
            bitcnt <= '0;
            warn   <= 1'b0;
        end
    end

    // Tick span since the first capture, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick <= '0;
        else if (capture && cnt0 == '0)
            tick <= TICK_W'(1);
        else if (!cs_chg && bitcnt != '0 && tick != TICK_TOP)
            tick <= tick + TICK_W'(1);
    end

    // Registered word strobe, warning and duration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_warn  <= 1'b0;
            word_ticks <= '0;
        end else begin
            word_valid <= done;
            if (done) begin
                word_warn  <= warn_new;
                word_ticks <= dur_now;
            end
        end
    end

    // R3: a completed word is strobed for a single cycle only.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R3: the running bit index never reaches the word length.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt < len_eff);

    // R7: every reported word spans at least one tick.
    a_r7_ticks_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> word_ticks != '0);

endmodule

// File: rtl/spi_mon.sv
// spi_mon: passive SPI bus monitor. Synchronises the four bus lines, finds
// capture edges and chip-select changes, assembles full-duplex words and
// reports chip-select transitions as events.
// Assumes: the system clock is at least a few times faster than the serial
// clock and configuration is static while a word is in progress.
module spi_mon
    import spi_mon_pkg::*;
#(
    parameter int unsigned MAX_W       = 32,
    parameter int unsigned TICK_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = $clog2(MAX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic [CNT_W-1:0]  cfg_word_len,
    input  logic              cfg_cs_active_high,
    input  logic              cfg_cs_en,
    input  logic              cfg_mosi_en,
    input  logic              cfg_miso_en,
    input  logic              bus_sck,
    input  logic              bus_mosi,
    input  logic              bus_miso,
    input  logic              bus_cs,
    output logic              word_valid,
    output logic [MAX_W-1:0]  word_mosi,
    output logic [MAX_W-1:0]  word_miso,
    output logic              word_warn,
    output logic [TICK_W-1:0] word_ticks,
    output logic              cs_evt_valid,
    output logic              cs_evt_old,
    output logic              cs_evt_new
);

    localparam int unsigned PIN_SCK  = 0;
    localparam int unsigned PIN_MOSI = 1;
    localparam int unsigned PIN_MISO = 2;
    localparam int unsigned PIN_CS   = 3;
    localparam int unsigned NUM_PINS = 4;

    spi_mon_cfg_t                          cfg;
    logic [NUM_PINS-1:0]                   pins_cur;
    logic [NUM_PINS-1:0]                   pins_prv;
    logic                                  pins_vld;
    logic                                  capture;
    logic                                  cs_chg;
    logic                                  cs_off;
    logic [NUM_LANES-1:0]                  lane_bit;
    logic [NUM_LANES-1:0]                  lane_en;
    logic [NUM_LANES-1:0][MAX_W-1:0]       lane_word;

    // Gather the static configuration and lane routing.
    always_comb begin
        cfg.cpol           = cfg_cpol;
        cfg.cpha           = cfg_cpha;
        cfg.lsb_first      = cfg_lsb_first;
        cfg.cs_active_high = cfg_cs_active_high;
        cfg.cs_en          = cfg_cs_en;
        lane_bit[LANE_MOSI] = pins_cur[PIN_MOSI];
        lane_bit[LANE_MISO] = pins_cur[PIN_MISO];
        lane_en[LANE_MOSI]  = cfg_mosi_en;
        lane_en[LANE_MISO]  = cfg_miso_en;
    end

    spi_mon_sync #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({bus_cs, bus_miso, bus_mosi, bus_sck}),
        .cur   (pins_cur),
        .prv   (pins_prv),
        .vld   (pins_vld)
    );

    spi_mon_edge u_edge (
        .cfg     (cfg),
        .vld     (pins_vld),
        .sck_cur (pins_cur[PIN_SCK]),
        .sck_prv (pins_prv[PIN_SCK]),
        .cs_cur  (pins_cur[PIN_CS]),
        .cs_prv  (pins_prv[PIN_CS]),
        .capture (capture),
        .cs_chg  (cs_chg),
        .cs_off  (cs_off)
    );

    spi_mon_word #(
        .MAX_W  (MAX_W),
        .TICK_W (TICK_W),
        .CNT_W  (CNT_W)
    ) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .cs_chg     (cs_chg),
        .cs_off     (cs_off),
        .lane_bit   (lane_bit),
        .lane_en    (lane_en),
        .lsb_first  (cfg_lsb_first),
        .word_len   (cfg_word_len),
        .word_valid (word_valid),
        .word_data  (lane_word),
        .word_warn  (word_warn),
        .word_ticks (word_ticks)
    );

    assign word_mosi = lane_word[LANE_MOSI];
    assign word_miso = lane_word[LANE_MISO];

    // Register the chip-select event with its old and new levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_evt_valid <= 1'b0;
            cs_evt_old   <= 1'b0;
            cs_evt_new   <= 1'b0;
        end else begin
            cs_evt_valid <= cs_chg;
            if (cs_chg) begin
                cs_evt_old <= pins_prv[PIN_CS];
                cs_evt_new <= pins_cur[PIN_CS];
            end
        end
    end

    // R4: an event always reports a real transition.
    a_r4_evt_differs: assert property (@(posedge clk) disable iff (!rst_n)
        cs_evt_valid |-> cs_evt_old != cs_evt_new);

    // R9: events only appear while chip-select monitoring was enabled.
    a_r9_evt_needs_monitor: assert property (@(posedge clk) disable iff (!rst_n)
        cs_evt_valid |-> $past(cfg_cs_en));

    // R8: a disabled controller-to-peripheral lane reports zero.
    a_r8_mosi_off: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !cfg_mosi_en) |-> word_mosi == '0);

endmodule

// File: tb/tb_spi_mon.sv
module tb_spi_mon;

    localparam int MAX_W  = 32;
    localparam int TICK_W = 16;
    localparam int CNT_W  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;
    logic [CNT_W-1:0] cfg_len = 6'd8;
    logic cfg_cs_hi = 1'b0, cfg_cs_en = 1'b1, cfg_mosi_en = 1'b1, cfg_miso_en = 1'b1;
    logic bus_sck = 1'b0, bus_mosi = 1'b0, bus_miso = 1'b0, bus_cs = 1'b1;

    logic              word_valid, word_warn;
    logic [MAX_W-1:0]  word_mosi, word_miso;
    logic [TICK_W-1:0] word_ticks;
    logic              cs_evt_valid, cs_evt_old, cs_evt_new;

    spi_mon dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb),
        .cfg_word_len(cfg_len), .cfg_cs_active_high(cfg_cs_hi), .cfg_cs_en(cfg_cs_en),
        .cfg_mosi_en(cfg_mosi_en), .cfg_miso_en(cfg_miso_en),
        .bus_sck(bus_sck), .bus_mosi(bus_mosi), .bus_miso(bus_miso), .bus_cs(bus_cs),
        .word_valid(word_valid), .word_mosi(word_mosi), .word_miso(word_miso),
        .word_warn(word_warn), .word_ticks(word_ticks),
        .cs_evt_valid(cs_evt_valid), .cs_evt_old(cs_evt_old), .cs_evt_new(cs_evt_new)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        logic [31:0] mo;
        logic [31:0] mi;
        logic        warn;
        int          ticks;
        string       tag;
    } exp_t;

    exp_t        wq[$];
    logic [1:0]  cq[$];
    exp_t        e_cur;
    logic [1:0]  c_cur;
    int checks = 0, errors = 0;
    int cyc = 0, t_first = 0, ev_seen = 0, ev_mark = 0;
    bit done_flag = 1'b0;

    always @(posedge clk) cyc++;

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mask_of(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    // Drive chip select; a monitored change is expected as an event.
    task automatic set_cs(logic v);
        if (cfg_cs_en && v !== bus_cs) cq.push_back({bus_cs, v});
        bus_cs = v;
    endtask

    // Clock bits k0..k1-1 of an n-bit word; push the expectation at the last one.
    task automatic run_bits(logic [31:0] mo, logic [31:0] mi, int n, int k0, int k1,
                            int h, bit push, logic warn, int flip_k, string tag);
        for (int k = k0; k < k1; k++) begin
            int idx;
            idx = cfg_lsb ? k : n - 1 - k;
            if (!cfg_cpha) begin
                bus_mosi = mo[idx]; bus_miso = mi[idx];
                wait_cyc(h);
                bus_sck = ~cfg_cpol;
            end else begin
                bus_sck = ~cfg_cpol;
                bus_mosi = mo[idx]; bus_miso = mi[idx];
                wait_cyc(h);
                bus_sck = cfg_cpol;
            end
            // this is the capture edge
            if (k == flip_k) set_cs(~bus_cs);
            if (k == 0) t_first = cyc;
            if (push && k == n - 1) begin
                exp_t e;
                e.mo    = mo & mask_of(n) & {32{cfg_mosi_en}};
                e.mi    = mi & mask_of(n) & {32{cfg_miso_en}};
                e.warn  = warn;
                e.ticks = cyc - t_first + 1;
                e.tag   = tag;
                wq.push_back(e);
            end
            wait_cyc(h);
            if (!cfg_cpha) bus_sck = cfg_cpol;
        end
    endtask

    task automatic run_word(logic [31:0] mo, logic [31:0] mi, int n, int h,
                            logic warn, string tag);
        run_bits(mo, mi, n, 0, n, h, 1'b1, warn, -1, tag);
        wait_cyc(4);
    endtask

    // Switch SPI mode with chip select deasserted, then reassert it.
    task automatic set_mode(logic p, logic a);
        set_cs(1'b1); wait_cyc(4);
        cfg_cpol = p; cfg_cpha = a; wait_cyc(2);
        bus_sck = p; wait_cyc(8);
        set_cs(1'b0); wait_cyc(8);
    endtask

    // Scoreboard monitor: compare design results against the queues.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (word_valid) begin
                if (wq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R3 unexpected word: got %0h/%0h expected none", word_mosi, word_miso);
                end else begin
                    e_cur = wq.pop_front();
                    chk(e_cur.tag, "mosi word", 64'(word_mosi), 64'(e_cur.mo));
                    chk(e_cur.tag, "miso word", 64'(word_miso), 64'(e_cur.mi));
                    chk("R6", "warning", 64'(word_warn), 64'(e_cur.warn));
                    chk("R7", "ticks", 64'(word_ticks), 64'(e_cur.ticks));
                end
            end
            if (cs_evt_valid) begin
                ev_seen++;
                if (cq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4 unexpected cs event: got %0b->%0b expected none", cs_evt_old, cs_evt_new);
                end else begin
                    c_cur = cq.pop_front();
                    chk("R4", "cs event levels", 64'({cs_evt_old, cs_evt_new}), 64'(c_cur));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        chk("R10", "reset word_valid", 64'(word_valid), 64'd0);
        chk("R10", "reset cs_evt_valid", 64'(cs_evt_valid), 64'd0);
        chk("R10", "reset word_mosi", 64'(word_mosi), 64'd0);
        chk("R10", "reset word_ticks", 64'(word_ticks), 64'd0);
        rst_n = 1'b1;
        wait_cyc(12);
        chk("R10", "no event at release", 64'(ev_seen), 64'd0);

        set_cs(1'b0); wait_cyc(6);
        // R1 mode 0, back-to-back words
        run_word(32'hA5, 32'h3C, 8, 2, 1'b0, "R1");
        run_word(32'h81, 32'h7E, 8, 3, 1'b0, "R3");
        // R1 modes 1, 2, 3
        set_mode(1'b0, 1'b1); run_word(32'h5A, 32'hC3, 8, 2, 1'b0, "R1");
        set_mode(1'b1, 1'b0); run_word(32'h96, 32'h1E, 8, 3, 1'b0, "R1");
        set_mode(1'b1, 1'b1); run_word(32'h37, 32'hE2, 8, 2, 1'b0, "R1");
        set_mode(1'b0, 1'b0);
        // R2 bit order
        cfg_lsb = 1'b1; run_word(32'h01, 32'hB4, 8, 2, 1'b0, "R2");
        cfg_lsb = 1'b0;
        // R3 word lengths
        cfg_len = 6'd5;  run_word(32'h13, 32'h0C, 5, 2, 1'b0, "R3");
        cfg_len = 6'd32; run_word(32'hDEADBEEF, 32'h12345678, 32, 2, 1'b0, "R3");
        cfg_len = 6'd1;  run_word(32'h1, 32'h0, 1, 2, 1'b0, "R3");
        run_word(32'h0, 32'h1, 1, 3, 1'b0, "R3");
        cfg_len = 6'd8;
        // R5 partial discarded by chip-select toggle
        run_bits(32'hFF, 32'hFF, 8, 0, 3, 2, 1'b0, 1'b0, -1, "R5");
        set_cs(1'b1); wait_cyc(5); set_cs(1'b0); wait_cyc(5);
        run_word(32'h96, 32'h69, 8, 2, 1'b0, "R5");
        // R5 capture coinciding with deassertion starts a new word (R6 warn)
        run_bits(32'hF0, 32'h0F, 8, 0, 3, 2, 1'b0, 1'b0, -1, "R5");
        run_bits(32'h2D, 32'hD2, 8, 0, 8, 2, 1'b1, 1'b1, 0, "R5");
        wait_cyc(4); set_cs(1'b0); wait_cyc(6);
        // R6 polarity: active-high with line low is deasserted
        cfg_cs_hi = 1'b1; wait_cyc(2);
        run_word(32'h3E, 32'h77, 8, 2, 1'b1, "R6");
        set_cs(1'b1); wait_cyc(5);
        run_word(32'h44, 32'h22, 8, 2, 1'b0, "R6");
        cfg_cs_hi = 1'b0; set_cs(1'b0); wait_cyc(6);
        // R8 lane enables
        cfg_mosi_en = 1'b0; run_word(32'hAB, 32'hCD, 8, 2, 1'b0, "R8");
        cfg_mosi_en = 1'b1; cfg_miso_en = 1'b0; run_word(32'hAB, 32'hCD, 8, 2, 1'b0, "R8");
        cfg_miso_en = 1'b1;
        // R9 chip-select monitoring disabled
        cfg_cs_en = 1'b0; wait_cyc(6);
        ev_mark = ev_seen;
        set_cs(1'b1); wait_cyc(5); set_cs(1'b0); wait_cyc(5);
        run_bits(32'hC9, 32'h36, 8, 0, 3, 2, 1'b0, 1'b0, -1, "R9");
        set_cs(1'b1); wait_cyc(4);
        run_bits(32'hC9, 32'h36, 8, 3, 8, 2, 1'b1, 1'b0, -1, "R9");
        wait_cyc(6);
        set_cs(1'b0); wait_cyc(6);
        chk("R9", "events while disabled", 64'(ev_seen - ev_mark), 64'd0);
        cfg_cs_en = 1'b1;

        wait_cyc(20);
        chk("R3", "words outstanding", 64'(wq.size()), 64'd0);
        chk("R4", "events outstanding", 64'(cq.size()), 64'd0);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule